// File: doc/BRIEF.md
# Supply Monitor Sampling Controller

This block runs a supply-voltage monitor from a slow clock. A 32-bit mode register holds a 4-bit threshold code, a 3-bit sampling mode, a reset-request enable and an interrupt enable. The threshold code goes unchanged to an external analog comparator. The block drives that comparator's enable strobe, which is either held off, held on, or raised for one slow-clock period in every window of configurable length.

The comparator's trip output counts only when it is sampled at the end of a period in which the enable strobe was high. A counted trip sets a sticky status flag that clears when software reads it. A counted trip can also drive an active-low core reset request, which is stretched by a fixed number of periods after the last trip. The interrupt line is the status flag gated by the interrupt enable.

Software reaches the block through a simple two-word register port. Select 0 is the mode word. Select 1 is the status word.

Top module: `supmon_ctrl`

## Requirements
- R1: After reset the mode word reads 0x0000_0000 and the status word reads 0. At the ports, cmp_en is 0, cmp_level is 0, irq is 0 and core_rst_n is 1.
- R2: Mode-word bits 3:0 hold the threshold code 0..15, where each step is 0.1 V from 1.9 V at code 0. cmp_level equals this field in every cycle after the write that set it.
- R3: Mode-word bits 10:8 select the sampling mode. Code 0 holds cmp_en low. Code 1 holds cmp_en high. Codes 2, 3 and 4 raise cmp_en for exactly one period at the start of each window of WIN_S, WIN_M and WIN_L periods respectively (defaults 32, 256, 2048).
- R4: Sampling codes 5, 6 and 7 behave like code 0. cmp_en stays low and no trip is counted.
- R5: The mode word reads back bits 3:0, 10:8, 12 and 13 as written, and every other bit reads 0. For example, writing 0xFFFF_FFFF reads back 0x0000_370F.
- R6: cmp_trip is counted only at a clock edge that ends a period in which cmp_en was high. A trip at any other time has no effect.
- R7: Status bit 0 is set by a counted trip and stays set until a read of select 1 clears it at that clock edge. If a trip is counted at the same edge as the read, the bit stays set.
- R8: irq is high exactly when the status bit and mode-word bit 13 are both set.
- R9: With mode-word bit 12 set, core_rst_n goes low in the period after a counted trip. It stays low while trips keep being counted and for RST_HOLD periods (default 3) after the last one. With bit 12 clear, a trip never lowers core_rst_n.
- R10: A write that changes the sampling mode restarts the window, so cmp_en is high in the period right after that write for modes 1 to 4. A write that keeps the same sampling mode does not disturb the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe (mode word only) |
| reg_rd | input | 1 | Read strobe (clears status when select is 1) |
| reg_sel | input | 1 | Register select: 0 mode word, 1 status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| cmp_trip | input | 1 | Comparator result, 1 means supply below threshold |
| cmp_en | output | 1 | Comparator enable strobe |
| cmp_level | output | 4 | Threshold code to the comparator |
| core_rst_n | output | 1 | Active-low core reset request |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the controller with window lengths of 4, 8 and 16 periods and a reset stretch of 3. With these lengths every duty-cycled mode wraps several times within a few dozen cycles, so the bench can check the spacing of the enable strobe, the restart on a mode change and the rejection of trips outside the strobe cycle by cycle. A stretch of 3 keeps the full reset pulse, including its release edge, inside a short scenario.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

  localparam int REG_W = 32;
  localparam int THR_W = 4;
  localparam int MODE_W = 3;

  localparam int THR_LSB = 0;
  localparam int MODE_LSB = 8;
  localparam int RSTEN_BIT = 12;
  localparam int IRQEN_BIT = 13;

  typedef logic [MODE_W-1:0] smode_t;

  localparam smode_t SM_OFF    = 3'd0;
  localparam smode_t SM_CONT   = 3'd1;
  localparam smode_t SM_WIN_S  = 3'd2;
  localparam smode_t SM_WIN_M  = 3'd3;
  localparam smode_t SM_WIN_L  = 3'd4;

  function automatic logic mode_is_cont(smode_t m);
    return m == SM_CONT;
  endfunction

  function automatic logic mode_is_duty(smode_t m);
    return (m == SM_WIN_S) || (m == SM_WIN_M) || (m == SM_WIN_L);
  endfunction

  // window length in slow-clock periods for a duty-cycled mode, 1 otherwise
  function automatic logic [31:0] win_period(smode_t m, int unsigned s,
                                             int unsigned md, int unsigned l);
    case (m)
      SM_WIN_S: return 32'(s);
      SM_WIN_M: return 32'(md);
      SM_WIN_L: return 32'(l);
      default:  return 32'd1;
    endcase
  endfunction

endpackage

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              det_hit,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [THR_W-1:0]  thr,
  output smode_t            mode,
  output logic              rst_en,
  output logic              irq_en,
  output logic              status,
  output logic              mode_wr,
  output logic              mode_restart,
  output logic              status_rd
);

  logic [THR_W-1:0] thr_q;
  smode_t           mode_q;
  logic             rsten_q;
  logic             irqen_q;
  logic             status_q;
  smode_t           new_mode;
  logic             unused_wbits;

  assign new_mode     = reg_wdata[MODE_LSB +: MODE_W];
  assign mode_wr      = reg_wr && !reg_sel;
  assign mode_restart = mode_wr && (new_mode != mode_q);
  assign status_rd    = reg_rd && reg_sel;
  assign unused_wbits = ^{reg_wdata[REG_W-1:IRQEN_BIT+1], reg_wdata[MODE_LSB+MODE_W],
                          reg_wdata[MODE_LSB-1:THR_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= '0;
      mode_q  <= SM_OFF;
      rsten_q <= 1'b0;
      irqen_q <= 1'b0;
    end else if (mode_wr) begin
      thr_q   <= reg_wdata[THR_LSB +: THR_W];
      mode_q  <= new_mode;
      rsten_q <= reg_wdata[RSTEN_BIT];
      irqen_q <= reg_wdata[IRQEN_BIT];
    end
  end

  // sticky flag: a counted trip wins over a clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          status_q <= 1'b0;
    else if (det_hit)    status_q <= 1'b1;
    else if (status_rd)  status_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[0] = status_q;
    end else begin
      reg_rdata[THR_LSB +: THR_W]   = thr_q;
      reg_rdata[MODE_LSB +: MODE_W] = mode_q;
      reg_rdata[RSTEN_BIT]          = rsten_q;
      reg_rdata[IRQEN_BIT]          = irqen_q;
    end
  end

  assign thr    = thr_q;
  assign mode   = mode_q;
  assign rst_en = rsten_q;
  assign irq_en = irqen_q;
  assign status = status_q;

endmodule

// File: rtl/supmon_window.sv
module supmon_window
  import supmon_pkg::*;
#(
  parameter int unsigned WIN_S = 32,
  parameter int unsigned WIN_M = 256,
  parameter int unsigned WIN_L = 2048
) (
  input  logic   clk,
  input  logic   rst_n,
  input  smode_t mode,
  input  logic   restart,
  output logic   cmp_en,
  output logic   mode_cont,
  output logic   mode_duty
);

  localparam int CNT_W = (WIN_L > 2) ? $clog2(WIN_L) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      period;
  logic             at_last;

  assign mode_cont = mode_is_cont(mode);
  assign mode_duty = mode_is_duty(mode);

  always_comb begin
    period  = win_period(mode, WIN_S, WIN_M, WIN_L);
    at_last = ({{(32-CNT_W){1'b0}}, cnt_q} == (period - 32'd1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart)            cnt_q <= '0;
    else if (!mode_duty)         cnt_q <= '0;
    else if (at_last)            cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign cmp_en = mode_cont || (mode_duty && (cnt_q == '0));

endmodule

// File: rtl/supmon_stretch.sv
module supmon_stretch #(
  parameter int unsigned RST_HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic core_rst_n
);

  localparam int HW = $clog2(RST_HOLD + 1);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hold_q <= '0;
    else if (trigger)         hold_q <= HW'(RST_HOLD);
    else if (hold_q != '0)    hold_q <= hold_q - 1'b1;
  end

  assign core_rst_n = (hold_q == '0);

endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter int unsigned WIN_S    = 32,
  parameter int unsigned WIN_M    = 256,
  parameter int unsigned WIN_L    = 2048,
  parameter int unsigned RST_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cmp_trip,
  output logic              cmp_en,
  output logic [THR_W-1:0]  cmp_level,
  output logic              core_rst_n,
  output logic              irq
);

  smode_t mode;
  logic   rst_en;
  logic   irq_en;
  logic   status;
  logic   mode_wr;
  logic   mode_restart;
  logic   status_rd;
  logic   mode_cont;
  logic   mode_duty;
  logic   mode_off;
  logic   det_hit;
  logic   rst_trig;

  supmon_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .det_hit      (det_hit),
    .reg_rdata    (reg_rdata),
    .thr          (cmp_level),
    .mode         (mode),
    .rst_en       (rst_en),
    .irq_en       (irq_en),
    .status       (status),
    .mode_wr      (mode_wr),
    .mode_restart (mode_restart),
    .status_rd    (status_rd)
  );

  supmon_window #(
    .WIN_S (WIN_S),
    .WIN_M (WIN_M),
    .WIN_L (WIN_L)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .restart   (mode_restart),
    .cmp_en    (cmp_en),
    .mode_cont (mode_cont),
    .mode_duty (mode_duty)
  );

  // a trip counts only at the edge closing an enabled period
  assign det_hit  = cmp_en && cmp_trip;
  assign rst_trig = det_hit && rst_en;
  assign mode_off = !mode_cont && !mode_duty;

  supmon_stretch #(
    .RST_HOLD (RST_HOLD)
  ) u_stretch (
    .clk        (clk),
    .rst_n      (rst_n),
    .trigger    (rst_trig),
    .core_rst_n (core_rst_n)
  );

  assign irq = status && irq_en;

endmodule

// File: rtl/supmon_ctrl_chk.sv
module supmon_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmp_en,
  input logic [3:0] cmp_level,
  input logic       core_rst_n,
  input logic       irq,
  input logic       det_hit,
  input logic       rst_en,
  input logic       irq_en,
  input logic       status,
  input logic       status_rd,
  input logic       mode_wr,
  input logic       mode_restart,
  input logic       mode_off,
  input logic       mode_cont,
  input logic       mode_duty
);

  a_r2_level_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(cmp_level));

  a_r3_cont_on: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cont |-> cmp_en);

  a_r3_single_period: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_duty && cmp_en && !mode_restart) |=> !cmp_en);

  a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off |-> !cmp_en);

  a_r6_gated_hit: assert property (@(posedge clk) disable iff (!rst_n)
    det_hit |-> cmp_en);

  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    det_hit |=> status);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !status_rd) |=> status);

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && status));

  a_r9_rst_assert: assert property (@(posedge clk) disable iff (!rst_n)
    (det_hit && rst_en) |=> !core_rst_n);

  a_r9_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_n) |-> $past(det_hit && rst_en));

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    mode_restart |=> (mode_off || cmp_en));

endmodule

bind supmon_ctrl supmon_ctrl_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmp_en       (cmp_en),
  .cmp_level    (cmp_level),
  .core_rst_n   (core_rst_n),
  .irq          (irq),
  .det_hit      (det_hit),
  .rst_en       (rst_en),
  .irq_en       (irq_en),
  .status       (status),
  .status_rd    (status_rd),
  .mode_wr      (mode_wr),
  .mode_restart (mode_restart),
  .mode_off     (mode_off),
  .mode_cont    (mode_cont),
  .mode_duty    (mode_duty)
);

// File: tb/test_supmon_ctrl.sv
`timescale 1ns/1ps
module test_supmon_ctrl;

  localparam int TW_S = 4;
  localparam int TW_M = 8;
  localparam int TW_L = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmp_trip = 1'b0;
  logic        cmp_en;
  logic [3:0]  cmp_level;
  logic        core_rst_n;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  supmon_ctrl #(
    .WIN_S (TW_S), .WIN_M (TW_M), .WIN_L (TW_L), .RST_HOLD (3)
  ) i_supmon_ctrl (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_rd (reg_rd),
    .reg_sel (reg_sel), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .cmp_trip (cmp_trip), .cmp_en (cmp_en), .cmp_level (cmp_level),
    .core_rst_n (core_rst_n), .irq (irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_mode(logic [31:0] v);
    reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = v;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_mode(output logic [31:0] v);
    reg_sel = 1'b0;
    #1 v = reg_rdata;
  endtask

  task automatic rd_status(output logic [31:0] v);
    reg_sel = 1'b1; reg_rd = 1'b1;
    #1 v = reg_rdata;
    step();
    reg_rd = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 cmp_en", 32'(cmp_en), 0);
    check("R1 cmp_level", 32'(cmp_level), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 core_rst_n", 32'(core_rst_n), 1);
    rd_mode(v);
    check("R1 mode word", v, 0);
    rd_status(v);
    check("R1 status word", v, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr_mode(32'hFFFF_FFFF);
    rd_mode(v);
    check("R5 readback all ones", v, 32'h0000_370F);
    wr_mode(32'h0000_2205);
    rd_mode(v);
    check("R5 readback mix", v, 32'h0000_2205);
    wr_mode(32'h0);
  endtask

  task automatic t_threshold();
    wr_mode(32'h0000_0007);
    check("R2 level 7", 32'(cmp_level), 7);
    step();
    check("R2 level held", 32'(cmp_level), 7);
    wr_mode(32'h0000_000F);
    check("R2 level 15", 32'(cmp_level), 15);
    wr_mode(32'h0);
    check("R2 level 0", 32'(cmp_level), 0);
  endtask

  task automatic t_modes();
    wr_mode(32'h0000_0100);
    for (int k = 0; k < 5; k++) begin
      check("R3 continuous", 32'(cmp_en), 1);
      step();
    end
    wr_mode(32'h0);
    for (int k = 0; k < 3; k++) begin
      check("R3 off", 32'(cmp_en), 0);
      step();
    end
    for (int m = 2; m <= 4; m++) begin
      int len;
      len = (m == 2) ? TW_S : (m == 3) ? TW_M : TW_L;
      wr_mode(32'(m) << 8);
      for (int k = 0; k < 3 * len; k++) begin
        check("R3 duty window", 32'(cmp_en), 32'((k % len) == 0));
        step();
      end
      wr_mode(32'h0);
    end
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    rd_status(v);
    for (int m = 5; m <= 7; m++) begin
      wr_mode(32'(m) << 8);
      cmp_trip = 1'b1;
      for (int k = 0; k < 4; k++) begin
        check("R4 reserved off", 32'(cmp_en), 0);
        step();
      end
      cmp_trip = 1'b0;
      rd_status(v);
      check("R4 no trip counted", v, 0);
    end
    wr_mode(32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr_mode(32'h0000_0200);
    for (int k = 0; k < 12; k++) begin
      cmp_trip = !cmp_en;
      step();
    end
    cmp_trip = 1'b0;
    rd_status(v);
    check("R6 trip outside window ignored", v, 0);
    while (!cmp_en) step();
    cmp_trip = 1'b1;
    step();
    cmp_trip = 1'b0;
    rd_status(v);
    check("R6 trip inside window counted", v, 1);
    wr_mode(32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    wr_mode(32'h0000_0100);
    cmp_trip = 1'b1;
    step();
    rd_status(v);
    check("R7 first read", v, 1);
    cmp_trip = 1'b0;
    rd_status(v);
    check("R7 set wins over clear", v, 1);
    rd_status(v);
    check("R7 cleared by read", v, 0);
    wr_mode(32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr_mode(32'h0000_0100);
    cmp_trip = 1'b1;
    step();
    cmp_trip = 1'b0;
    check("R8 irq masked", 32'(irq), 0);
    wr_mode(32'h0000_2100);
    check("R8 irq raised", 32'(irq), 1);
    rd_status(v);
    check("R8 irq drops on clear", 32'(irq), 0);
    wr_mode(32'h0);
  endtask

  task automatic t_rst_stretch();
    logic [31:0] v;
    wr_mode(32'h0000_1100);
    check("R9 idle high", 32'(core_rst_n), 1);
    cmp_trip = 1'b1;
    step();
    check("R9 low after trip", 32'(core_rst_n), 0);
    step();
    check("R9 low while trip", 32'(core_rst_n), 0);
    cmp_trip = 1'b0;
    step();
    check("R9 hold 1", 32'(core_rst_n), 0);
    step();
    check("R9 hold 2", 32'(core_rst_n), 0);
    step();
    check("R9 release", 32'(core_rst_n), 1);
    wr_mode(32'h0000_0100);
    cmp_trip = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R9 disabled no reset", 32'(core_rst_n), 1);
    end
    cmp_trip = 1'b0;
    rd_status(v);
    wr_mode(32'h0);
  endtask

  task automatic t_restart();
    wr_mode(32'h0000_0200);
    check("R10 first window", 32'(cmp_en), 1);
    step();
    check("R10 count 1", 32'(cmp_en), 0);
    wr_mode(32'h0000_0205);
    check("R10 same mode no restart", 32'(cmp_en), 0);
    step();
    check("R10 count 3", 32'(cmp_en), 0);
    step();
    check("R10 wrap", 32'(cmp_en), 1);
    step();
    wr_mode(32'h0000_0400);
    check("R10 change restarts", 32'(cmp_en), 1);
    step();
    check("R10 after restart", 32'(cmp_en), 0);
    wr_mode(32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_readback();
    t_threshold();
    t_modes();
    t_reserved();
    t_gate();
    t_sticky();
    t_irq();
    t_rst_stretch();
    t_restart();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule